// File: doc/BRIEF.md
# Framing Error Burst Injector

This block sits beside the transmit formatter of a seven-channel tributary multiplexer. It decides the value of every framing bit the formatter sends. Each channel works in one of three framing modes. The first is a single-bit F-bit mode. The other two are word modes: a 10-bit alignment word mode with four national bits, and a 9-bit alignment word mode. The formatter marks each framing-bit position with a strobe and flags the first bit of each alignment word. The block answers in the same cycle with the bit to send.

When a channel's control bit goes from 0 to 1, the block inverts that channel's framing for exactly four consecutive framing words, so that the far end loses alignment. It then returns to normal framing without further action. A burst always starts on a word boundary and is never queued. A mode change on a channel cancels any burst pending or running on that channel.

In the 10-bit word mode the block also supplies the four national bits from per-channel configuration.

Top module: `fault_burst_overlay`

## Requirements
- R1: A burst is armed only by a 0-to-1 change of the channel's `arm_i` bit, as seen at a clock edge. Keeping the bit at 1 arms no further burst. A new burst needs the bit to return to 0 and then rise again.
- R2: The seven channels are independent. Arming, bursts, mode and outputs on one channel never change another channel's outputs.
- R3: Mode code 0, and also code 3, is the F-bit mode. Every framing strobe is a one-bit word, and `fbit_o` equals the nominal `t2f_i`. During a burst, four consecutive F bits are sent inverted.
- R4: Mode code 1 is the 10-bit word mode. The word is sent MSB first, one bit per strobe, and normally reads 1111010000. During a burst each of the four words is sent as 0000101111.
- R5: Mode code 2 is the 9-bit word mode. The word is sent MSB first and normally reads 111010000. During a burst each of the four words is sent as 000101111.
- R6: A burst covers exactly four consecutive framing words. After the fourth, normal framing resumes with no action by software.
- R7: A rising edge that arrives while a burst is pending, or while an inverted word is still being sent, is dropped and not queued.
- R8: An arming edge that arrives in the middle of a word leaves the rest of that word unchanged. Inversion starts with the first bit of the next word.
- R9: A change of a channel's mode code cancels that channel's pending or running burst and restarts its bit position. A rising edge in the same cycle as the mode change is dropped.
- R10: In mode 1, a national-bit strobe makes `natl_vld_o` 1 and makes `natl_o` equal to configuration bit `nat_cfg_i[4*ch + nsel]`, where nsel is the channel's 2-bit select.
- R11: In modes 0, 2 and 3, the national-bit configuration is ignored: `natl_vld_o` and `natl_o` stay 0.
- R12: After reset no channel has a burst. With no strobe present, `fbit_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_i | input | 7 | Per-channel burst request bit |
| mode_i | input | 14 | Two-bit mode code per channel; channel c uses bits [2c+1:2c] |
| fstb_i | input | 7 | Framing-bit position strobe per channel |
| wstart_i | input | 7 | With `fstb_i`, marks the first bit of an alignment word |
| t2f_i | input | 7 | Nominal F bit per channel, used in the F-bit mode |
| nat_cfg_i | input | 28 | Four national-bit settings per channel |
| nstb_i | input | 7 | National-bit position strobe per channel |
| nsel_i | input | 14 | Index of the national bit, 0 to 3, per channel |
| fbit_o | output | 7 | Framing bit to send; 0 when there is no strobe |
| natl_o | output | 7 | National bit to send |
| natl_vld_o | output | 7 | National bit is driven by this block |

## Verification
Assertions check the following on every cycle: a pending burst appears only after a rising edge of the control bit and never while one is in progress; the burst word counter stays below four; inversion only begins on a word-start strobe; and a mode change leaves the channel idle on the next cycle. Several behaviours can only be shown by the bench's scenarios: the exact bit patterns in each mode, a count of exactly four inverted words followed by normal framing, the absence of a queued second burst, and isolation between channels. The bench also covers national-bit selection and national bits being ignored outside the 10-bit mode.

// File: rtl/fbo_pkg.sv
package fbo_pkg;

    typedef enum logic [1:0] {
        FM_FBIT  = 2'd0,
        FM_W10   = 2'd1,
        FM_W9    = 2'd2,
        FM_FBIT2 = 2'd3
    } fmode_e;

    localparam int          W10_LEN     = 10;
    localparam int          W9_LEN      = 9;
    localparam logic [9:0]  W10_WORD    = 10'b1111010000;
    localparam logic [8:0]  W9_WORD     = 9'b111010000;
    localparam int          BURST_WORDS = 4;
    localparam int          CNT_W       = $clog2(BURST_WORDS + 1);
    localparam int          POS_W       = $clog2(W10_LEN + 1);

    typedef struct packed {
        logic             arm;
        logic             pend;
        logic             act;
        logic             inv;
        logic [CNT_W-1:0] cnt;
        logic [POS_W-1:0] pos;
        logic [1:0]       mode;
    } chan_st_t;

    function automatic logic is_fbit(logic [1:0] m);
        return (m == FM_FBIT) || (m == FM_FBIT2);
    endfunction

    function automatic logic word_bit(logic [1:0] m, logic [POS_W-1:0] idx, logic nom);
        logic b;
        b = 1'b0;
        case (m)
            FM_W10:  if (int'(idx) < W10_LEN) b = W10_WORD[W10_LEN-1-int'(idx)];
            FM_W9:   if (int'(idx) < W9_LEN)  b = W9_WORD[W9_LEN-1-int'(idx)];
            default: b = nom;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/fbo_chan.sv
module fbo_chan
    import fbo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm_i,
    input  logic [1:0] mode_i,
    input  logic       fstb_i,
    input  logic       wstart_i,
    input  logic       t2f_i,
    output logic       fbit_o
);

    chan_st_t         st_d, st_q;
    logic             fmode;
    logic             ws;
    logic             inv_now;
    logic             busy;
    logic             mchg;
    logic [POS_W-1:0] idx;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        fmode   = is_fbit(mode_i);
        ws      = fstb_i && (fmode || wstart_i);
        idx     = (fmode || wstart_i) ? '0 : st_q.pos;
        inv_now = ws ? (st_q.act || st_q.pend) : st_q.inv;
        busy    = st_q.pend || st_q.act || st_q.inv;
        mchg    = (mode_i != st_q.mode);
        cnt_inc = st_q.cnt + 1'b1;

        st_d      = st_q;
        st_d.arm  = arm_i;
        st_d.mode = mode_i;

        if (mchg) begin
            st_d.pend = 1'b0;
            st_d.act  = 1'b0;
            st_d.inv  = 1'b0;
            st_d.cnt  = '0;
            st_d.pos  = '0;
        end else begin
            if (fstb_i) begin
                st_d.pos = (idx == {POS_W{1'b1}}) ? idx : idx + 1'b1;
                if (ws) begin
                    st_d.inv  = inv_now;
                    st_d.pend = 1'b0;
                    if (inv_now) begin
                        if (int'(cnt_inc) < BURST_WORDS) begin
                            st_d.cnt = cnt_inc;
                            st_d.act = 1'b1;
                        end else begin
                            st_d.cnt = '0;
                            st_d.act = 1'b0;
                        end
                    end
                end
            end
            if (arm_i && !st_q.arm && !busy) begin
                st_d.pend = 1'b1;
            end
        end

        fbit_o = fstb_i ? (word_bit(mode_i, idx, t2f_i) ^ inv_now) : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_PEND_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.pend) |-> ($past(arm_i) && !$past(st_q.arm))); // R1

    AST_NO_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.pend) |-> !$past(st_q.act || st_q.inv)); // R7

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.cnt) < BURST_WORDS); // R6

    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.inv) |-> $past(ws)); // R8

    AST_MODE_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != st_q.mode) |=> !(st_q.pend || st_q.act || st_q.inv)); // R9

endmodule

// File: rtl/fbo_natl.sv
module fbo_natl
    import fbo_pkg::*;
#(
    parameter int NNAT = 4,
    localparam int SEL_W = $clog2(NNAT)
) (
    input  logic [1:0]       mode_i,
    input  logic             stb_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [NNAT-1:0]  cfg_i,
    output logic             natl_o,
    output logic             vld_o
);

    always_comb begin
        vld_o  = stb_i && (mode_i == FM_W10);
        natl_o = 1'b0;
        if (vld_o && (int'(sel_i) < NNAT)) begin
            natl_o = cfg_i[sel_i];
        end
    end

endmodule

// File: rtl/fault_burst_overlay.sv
module fault_burst_overlay
    import fbo_pkg::*;
#(
    parameter int NCH  = 7,
    parameter int NNAT = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NCH-1:0]              arm_i,
    input  logic [2*NCH-1:0]            mode_i,
    input  logic [NCH-1:0]              fstb_i,
    input  logic [NCH-1:0]              wstart_i,
    input  logic [NCH-1:0]              t2f_i,
    input  logic [NNAT*NCH-1:0]         nat_cfg_i,
    input  logic [NCH-1:0]              nstb_i,
    input  logic [$clog2(NNAT)*NCH-1:0] nsel_i,
    output logic [NCH-1:0]              fbit_o,
    output logic [NCH-1:0]              natl_o,
    output logic [NCH-1:0]              natl_vld_o
);

    localparam int SEL_W = $clog2(NNAT);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        fbo_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .arm_i    (arm_i[c]),
            .mode_i   (mode_i[2*c +: 2]),
            .fstb_i   (fstb_i[c]),
            .wstart_i (wstart_i[c]),
            .t2f_i    (t2f_i[c]),
            .fbit_o   (fbit_o[c])
        );

        fbo_natl #(.NNAT(NNAT)) u_natl (
            .mode_i (mode_i[2*c +: 2]),
            .stb_i  (nstb_i[c]),
            .sel_i  (nsel_i[SEL_W*c +: SEL_W]),
            .cfg_i  (nat_cfg_i[NNAT*c +: NNAT]),
            .natl_o (natl_o[c]),
            .vld_o  (natl_vld_o[c])
        );
    end

endmodule

// File: tb/fault_burst_overlay_test.sv
module fault_burst_overlay_test;

    localparam int NCH  = 7;
    localparam int NNAT = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    arm_i = '0;
    logic [2*NCH-1:0]  mode_i = '0;
    logic [NCH-1:0]    fstb_i = '0;
    logic [NCH-1:0]    wstart_i = '0;
    logic [NCH-1:0]    t2f_i = '0;
    logic [4*NCH-1:0]  nat_cfg_i = '0;
    logic [NCH-1:0]    nstb_i = '0;
    logic [2*NCH-1:0]  nsel_i = '0;
    logic [NCH-1:0]    fbit_o;
    logic [NCH-1:0]    natl_o;
    logic [NCH-1:0]    natl_vld_o;

    int n_cmp = 0;
    int n_err = 0;
    bit done = 0;
    logic nom = 1'b0;

    always #2 clk = ~clk;

    fault_burst_overlay #(.NCH(NCH), .NNAT(NNAT)) uut (
        .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .mode_i(mode_i),
        .fstb_i(fstb_i), .wstart_i(wstart_i), .t2f_i(t2f_i),
        .nat_cfg_i(nat_cfg_i), .nstb_i(nstb_i), .nsel_i(nsel_i),
        .fbit_o(fbit_o), .natl_o(natl_o), .natl_vld_o(natl_vld_o)
    );

    typedef struct packed {
        logic [2:0] ch;
        logic [1:0] mode;
        logic [5:0] mask;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{ch: 3'd0, mode: 2'd1, mask: 6'b111100},
        '{ch: 3'd3, mode: 2'd2, mask: 6'b111100},
        '{ch: 3'd6, mode: 2'd0, mask: 6'b111100},
        '{ch: 3'd2, mode: 2'd3, mask: 6'b111100},
        '{ch: 3'd4, mode: 2'd1, mask: 6'b111100},
        '{ch: 3'd5, mode: 2'd2, mask: 6'b111100}
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic ref_bit(logic [1:0] m, int i, logic n);
        logic [9:0] w10;
        logic [8:0] w9;
        w10 = 10'b1111010000;
        w9  = 9'b111010000;
        if (m == 2'd1) return w10[9-i];
        if (m == 2'd2) return w9[8-i];
        return n;
    endfunction

    task automatic send_word(int ch, logic [1:0] m, logic inv, string req, int trig_at = -1);
        int len;
        len = (m == 2'd1) ? 10 : (m == 2'd2) ? 9 : 1;
        nom = ~nom;
        for (int i = 0; i < len; i++) begin
            fstb_i[ch]   = 1'b1;
            wstart_i[ch] = (i == 0);
            t2f_i[ch]    = nom;
            if (i == trig_at) arm_i[ch] = 1'b1;
            @(negedge clk);
            check(req, fbit_o[ch], ref_bit(m, i, nom) ^ inv);
            step();
        end
        fstb_i[ch]   = 1'b0;
        wstart_i[ch] = 1'b0;
    endtask

    task automatic set_mode(int ch, logic [1:0] m);
        mode_i[2*ch +: 2] = m;
        step();
        step();
    endtask

    task automatic rearm(int ch);
        arm_i[ch] = 1'b0;
        step();
        arm_i[ch] = 1'b1;
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R12: reset state, no strobes
        @(negedge clk);
        check("R12 fbit idle", |fbit_o, 1'b0);
        check("R12 natl idle", |natl_vld_o, 1'b0);
        step();
        send_word(1, 2'd0, 1'b0, "R12 no burst after reset");

        // Table walk: burst of four words then normal, per mode (R3 R4 R5 R6)
        foreach (VECS[v]) begin
            set_mode(int'(VECS[v].ch), VECS[v].mode);
            rearm(int'(VECS[v].ch));
            for (int w = 0; w < 6; w++) begin
                send_word(int'(VECS[v].ch), VECS[v].mode, VECS[v].mask[5-w],
                          (VECS[v].mode == 2'd1) ? "R4 R6" :
                          (VECS[v].mode == 2'd2) ? "R5 R6" : "R3 R6");
            end
        end

        // R1: control bit held high starts nothing more
        for (int w = 0; w < 3; w++) send_word(0, 2'd1, 1'b0, "R1 held high");

        // R7: second rising edge during a burst is not queued
        set_mode(1, 2'd1);
        rearm(1);
        send_word(1, 2'd1, 1'b1, "R7");
        send_word(1, 2'd1, 1'b1, "R7");
        rearm(1);
        send_word(1, 2'd1, 1'b1, "R7");
        send_word(1, 2'd1, 1'b1, "R7");
        send_word(1, 2'd1, 1'b0, "R7 not queued");
        send_word(1, 2'd1, 1'b0, "R7 not queued");

        // R8: trigger mid-word waits for next word start
        arm_i[1] = 1'b0;
        step();
        send_word(1, 2'd1, 1'b0, "R8 rest of word unchanged", 4);
        for (int w = 0; w < 4; w++) send_word(1, 2'd1, 1'b1, "R8 burst from next word");
        send_word(1, 2'd1, 1'b0, "R8 back to normal");

        // R9: mode change cancels burst
        rearm(3);
        send_word(3, 2'd2, 1'b1, "R9 burst started");
        set_mode(3, 2'd1);
        send_word(3, 2'd1, 1'b0, "R9 cancelled");
        send_word(3, 2'd1, 1'b0, "R9 cancelled");

        // R9: rising edge in the same cycle as a mode change is dropped
        arm_i[3] = 1'b0;
        step();
        arm_i[3] = 1'b1;
        mode_i[2*3 +: 2] = 2'd2;
        step();
        step();
        send_word(3, 2'd2, 1'b0, "R9 edge with mode change dropped");

        // R2: pending burst on ch0 leaves ch5 untouched
        rearm(0);
        for (int w = 0; w < 2; w++) send_word(5, 2'd2, 1'b0, "R2 other channel normal");
        @(negedge clk);
        check("R2 ch0 quiet", fbit_o[0], 1'b0);
        step();
        for (int w = 0; w < 4; w++) send_word(0, 2'd1, 1'b1, "R2 ch0 burst kept");
        send_word(0, 2'd1, 1'b0, "R2 ch0 normal");

        // R10: national bits in 10-bit mode (ch4 is mode 1)
        nat_cfg_i[4*4 +: 4] = 4'b1010;
        for (int s = 0; s < 4; s++) begin
            nstb_i[4] = 1'b1;
            nsel_i[2*4 +: 2] = 2'(s);
            @(negedge clk);
            check("R10 valid", natl_vld_o[4], 1'b1);
            check("R10 value", natl_o[4], (s == 1 || s == 3));
            step();
        end
        nat_cfg_i[4*4 +: 4] = 4'b0101;
        nsel_i[2*4 +: 2] = 2'd0;
        @(negedge clk);
        check("R10 value follows cfg", natl_o[4], 1'b1);
        step();
        nstb_i[4] = 1'b0;

        // R11: national settings ignored in other modes (ch6 mode 0, ch5 mode 2, ch2 mode 3)
        nat_cfg_i = '1;
        nstb_i[6] = 1'b1;
        nstb_i[5] = 1'b1;
        nstb_i[2] = 1'b1;
        @(negedge clk);
        check("R11 mode0 vld", natl_vld_o[6], 1'b0);
        check("R11 mode0 bit", natl_o[6], 1'b0);
        check("R11 mode2 vld", natl_vld_o[5], 1'b0);
        check("R11 mode2 bit", natl_o[5], 1'b0);
        check("R11 mode3 bit", natl_o[2], 1'b0);
        step();
        nstb_i = '0;

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

endmodule